// File: doc/BRIEF.md
# Peak-and-Hold Current Regulator Controller

This block is the digital control core for one inductive load channel, such as a valve or solenoid coil. It sets the gate-drive enable so that the coil current first climbs to a peak level and then settles at a lower hold level. It works from a digitised current sample in milliamps and a free-running one-microsecond tick. Regulation is peak-comparator based. While the drive is on and the current is at or above the active threshold, the drive switches off for a fixed off-time and then switches back on.

Four regulation styles are available. The drive can simply follow the request with no regulation. It can regulate at the hold level only. It can make a single excursion to the peak level and then hold. It can also regulate at the peak level for a programmed time and then hold. A 20 µs blanking window follows every turn-on, whether caused by the request or by the regulator, and the comparator is ignored during that window. Configuration codes are captured at the start of each activation.

Top module: `ph_regulator`

## Requirements
- R1: While `rst_n` is low, and afterwards while `chan_req` stays low, `drive_en` is 0.
- R2: With `cfg_mode` = 00 (direct) captured, `drive_en` is 1 from the cycle after `chan_req` rises until `chan_req` falls, regardless of `cur_ma`.
- R3: When `chan_req` goes low, `drive_en` is 0 one cycle later and all timers are cleared. A new request turns the drive on one cycle after it rises, even if it arrives in the middle of an off-time.
- R4: After every turn-on, external or internal, `drive_en` stays 1 for exactly 20 ticks, whatever the value of `cur_ma`.
- R5: In hold mode (`cfg_mode` = 01), once blanking is over, the drive turns off one cycle after `cur_ma` reaches the hold level. `cfg_hold` 00/01/10/11 selects 700/1000/1400/2000 mA. A current one milliamp below the hold level keeps the drive on.
- R6: After each regulation turn-off, `drive_en` stays 0 for exactly the off-time and then turns on again. `cfg_off` 00/01/10/11 selects 100/200/300/400 ticks.
- R7: In single-peak mode (`cfg_mode` = 10), the hold level is ignored during the first on-phase, and that phase ends when `cur_ma` reaches the peak level. `cfg_peak` 00/01/10/11 selects 1200/1800/2400/3600 mA. From the first off-time onward, the hold level applies.
- R8: In timed-peak mode (`cfg_mode` = 11), the peak level applies until 800 + 400·`cfg_tpk` ticks after the activation edge, and the hold level applies after that. With the current between the two levels, the drive is on for exactly that many cycles.
- R9: Changes to the `cfg_*` inputs while a request is active have no effect until the next activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| chan_req | input | 1 | External channel-on request |
| cur_ma | input | CUR_W | Load current sample in mA |
| cfg_mode | input | 2 | Regulation mode code |
| cfg_peak | input | 2 | Peak level code |
| cfg_hold | input | 2 | Hold level code |
| cfg_off | input | 2 | Fixed off-time code |
| cfg_tpk | input | 3 | Peak duration code |
| drive_en | output | 1 | Gate-drive enable |

## Verification
The bench sweeps every hold and off-time code pair, every peak code and every peak-duration code. It measures on and off durations in cycles against values it derives from the code tables. The threshold is probed one milliamp below and exactly at the level, so a strict-versus-inclusive comparison error or a swapped code table shows up as a missed or early turn-off. Blanking is measured after both external and internal turn-ons; a window that is off by one tick, or that is skipped on re-entry, changes the 20-cycle count. The bench also targets the following failure modes: a timed-peak controller that switches to the hold level one cycle late, a request drop that does not clear a pending off-time, and configuration edits that leak into a running activation.

// File: rtl/ph_pkg.sv
// Package: shared types and code-to-value decoding for the peak-and-hold
// regulator. All levels are in mA, all durations in microsecond ticks.
package ph_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT     = 2'b00,
        MODE_HOLD       = 2'b01,
        MODE_PEAK_MIN   = 2'b10,
        MODE_PEAK_TIMED = 2'b11
    } reg_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ON   = 2'b01,
        ST_OFF  = 2'b10
    } phase_e;

    // Reset values of the captured configuration
    localparam logic [1:0] DEF_MODE = 2'b00;
    localparam logic [1:0] DEF_PEAK = 2'b10;
    localparam logic [1:0] DEF_HOLD = 2'b01;
    localparam logic [1:0] DEF_OFF  = 2'b01;
    localparam logic [2:0] DEF_TPK  = 3'b101;

    function automatic int peak_ma(input logic [1:0] code);
        case (code)
            2'b00:   return 1200;
            2'b01:   return 1800;
            2'b10:   return 2400;
            default: return 3600;
        endcase
    endfunction

    function automatic int hold_ma(input logic [1:0] code);
        case (code)
            2'b00:   return 700;
            2'b01:   return 1000;
            2'b10:   return 1400;
            default: return 2000;
        endcase
    endfunction

    function automatic int off_us(input logic [1:0] code);
        return 100 * (int'(code) + 1);
    endfunction

    function automatic int tpk_us(input logic [2:0] code);
        return 800 + 400 * int'(code);
    endfunction

endpackage

// File: rtl/ph_us_timer.sv
// Module: microsecond down-counter.
// Loads a duration, counts it down on us_tick, and pulses expire on the
// tick that finishes the count. clear has priority over load.
// Assumes load_val is nonzero whenever load is asserted.
module ph_us_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy,
    output logic         expire
);
    logic [W-1:0] cnt;

    // Count register: clear, reload or decrement on tick
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (clear)               cnt <= '0;
        else if (load)                cnt <= load_val;
        else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy   = (cnt != '0);
    assign expire = tick && (cnt == W'(1));

    AST_TMR_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> (cnt == '0));  // R6

endmodule

// File: rtl/ph_cfg_latch.sv
// Module: configuration capture.
// Samples the raw codes on capture and holds the decoded levels and
// off-time for the whole activation. Also gives the decoded peak duration
// of the live inputs so the peak timer can be loaded on the capture edge.
module ph_cfg_latch #(
    parameter int CUR_W  = 12,
    parameter int TIME_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [1:0]        mode_in,
    input  logic [1:0]        peak_in,
    input  logic [1:0]        hold_in,
    input  logic [1:0]        off_in,
    input  logic [2:0]        tpk_in,
    output ph_pkg::reg_mode_e mode_q,
    output logic [CUR_W-1:0]  peak_lvl,
    output logic [CUR_W-1:0]  hold_lvl,
    output logic [TIME_W-1:0] off_len,
    output logic [TIME_W-1:0] tpk_now
);
    import ph_pkg::*;

    // Captured configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= reg_mode_e'(DEF_MODE);
            peak_lvl <= CUR_W'(peak_ma(DEF_PEAK));
            hold_lvl <= CUR_W'(hold_ma(DEF_HOLD));
            off_len  <= TIME_W'(off_us(DEF_OFF));
        end else if (capture) begin
            mode_q   <= reg_mode_e'(mode_in);
            peak_lvl <= CUR_W'(peak_ma(peak_in));
            hold_lvl <= CUR_W'(hold_ma(hold_in));
            off_len  <= TIME_W'(off_us(off_in));
        end
    end

    // Peak duration of the live inputs, used only on the capture edge
    assign tpk_now = TIME_W'(tpk_us(tpk_in));

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(hold_lvl) && $stable(peak_lvl) && $stable(mode_q)));  // R9

endmodule

// File: rtl/ph_regulator.sv
// Module: peak-and-hold regulator top.
// Sequences idle / on / off phases. It compares cur_ma with the peak or
// hold level after blanking, runs the fixed off-time and the peak-duration
// timer, and drives drive_en from the phase register.
// Assumes us_tick is a single-cycle pulse and cur_ma is already synchronous.
module ph_regulator #(
    parameter int CUR_W    = 12,
    parameter int TIME_W   = 12,
    parameter int BLANK_US = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             chan_req,
    input  logic [CUR_W-1:0] cur_ma,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_peak,
    input  logic [1:0]       cfg_hold,
    input  logic [1:0]       cfg_off,
    input  logic [2:0]       cfg_tpk,
    output logic             drive_en
);
    import ph_pkg::*;

    localparam logic [TIME_W-1:0] BLANK_LEN = TIME_W'(BLANK_US);

    phase_e            state, state_d;
    logic              peak_phase, peak_d;
    logic              activate, blank_load, off_load;
    logic              blank_busy, blank_exp, off_busy, off_exp, pk_busy, pk_exp;
    logic              cmp_ok, over;
    reg_mode_e         mode_q;
    logic [CUR_W-1:0]  peak_lvl, hold_lvl, thr;
    logic [TIME_W-1:0] off_len, tpk_now;

    assign activate = (state == ST_IDLE) && chan_req;

    ph_cfg_latch #(.CUR_W(CUR_W), .TIME_W(TIME_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .capture(activate),
        .mode_in(cfg_mode), .peak_in(cfg_peak), .hold_in(cfg_hold),
        .off_in(cfg_off), .tpk_in(cfg_tpk),
        .mode_q(mode_q), .peak_lvl(peak_lvl), .hold_lvl(hold_lvl),
        .off_len(off_len), .tpk_now(tpk_now)
    );

    ph_us_timer #(.W(TIME_W)) u_blank (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .clear(!chan_req),
        .load(blank_load), .load_val(BLANK_LEN),
        .busy(blank_busy), .expire(blank_exp)
    );

    ph_us_timer #(.W(TIME_W)) u_off (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .clear(!chan_req),
        .load(off_load), .load_val(off_len),
        .busy(off_busy), .expire(off_exp)
    );

    ph_us_timer #(.W(TIME_W)) u_peak (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .clear(!chan_req),
        .load(activate), .load_val(tpk_now),
        .busy(pk_busy), .expire(pk_exp)
    );

    // Active threshold: the peak level is used until the peak phase ends
    assign thr = (peak_phase && !(mode_q == MODE_PEAK_TIMED && pk_exp)) ? peak_lvl : hold_lvl;
    // The comparator counts only once the blanking window has elapsed
    assign cmp_ok = !blank_busy || blank_exp;
    assign over   = (cur_ma >= thr);

    // Next phase, peak flag and timer loads
    always_comb begin
        state_d    = state;
        peak_d     = peak_phase;
        blank_load = 1'b0;
        off_load   = 1'b0;
        if (!chan_req) begin
            state_d = ST_IDLE;
            peak_d  = 1'b0;
        end else begin
            if (state != ST_IDLE && mode_q == MODE_PEAK_TIMED && pk_exp)
                peak_d = 1'b0;
            case (state)
                ST_IDLE: begin
                    state_d    = ST_ON;
                    blank_load = 1'b1;
                    peak_d     = (cfg_mode == MODE_PEAK_MIN) || (cfg_mode == MODE_PEAK_TIMED);
                end
                ST_ON: begin
                    if (mode_q != MODE_DIRECT && cmp_ok && over) begin
                        state_d  = ST_OFF;
                        off_load = 1'b1;
                        if (mode_q == MODE_PEAK_MIN) peak_d = 1'b0;
                    end
                end
                ST_OFF: begin
                    if (off_exp) begin
                        state_d    = ST_ON;
                        blank_load = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Phase and peak-flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            peak_phase <= 1'b0;
        end else begin
            state      <= state_d;
            peak_phase <= peak_d;
        end
    end

    assign drive_en = (state == ST_ON);

    AST_REQ_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_req |=> !drive_en);  // R3
    AST_DIRECT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && mode_q == MODE_DIRECT && chan_req) |=> drive_en);  // R2
    AST_BLANK_KEEPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && blank_busy && !blank_exp && chan_req) |=> drive_en);  // R4
    AST_OFF_TIMER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> off_busy);  // R6
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !off_exp && chan_req) |=> !drive_en);  // R6
    AST_PEAK_MIN_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PEAK_MIN && state == ST_OFF) |-> !peak_phase);  // R7
    AST_PEAK_TIMED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PEAK_TIMED && state != ST_IDLE && pk_busy && !pk_exp) |-> peak_phase);  // R8

endmodule

// File: tb/tb_ph_regulator.sv
// Bench: sweeps the level and time codes with us_tick held high, so one
// tick equals one cycle, and measures drive on/off durations in cycles.
module tb_ph_regulator;
    localparam int CLK_NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b1;
    logic        chan_req = 1'b0;
    logic [11:0] cur_ma = '0;
    logic [1:0]  cfg_mode = '0, cfg_peak = '0, cfg_hold = '0, cfg_off = '0;
    logic [2:0]  cfg_tpk = '0;
    logic        drive_en;
    int          n_tests = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    ph_regulator dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .chan_req(chan_req),
        .cur_ma(cur_ma), .cfg_mode(cfg_mode), .cfg_peak(cfg_peak),
        .cfg_hold(cfg_hold), .cfg_off(cfg_off), .cfg_tpk(cfg_tpk),
        .drive_en(drive_en)
    );

    function automatic int e_peak(int c); return (c == 0) ? 1200 : (c == 1) ? 1800 : (c == 2) ? 2400 : 3600; endfunction
    function automatic int e_hold(int c); return (c == 0) ? 700 : (c == 1) ? 1000 : (c == 2) ? 1400 : 2000; endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (drive_en && n < 10000) begin n++; step(); end
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!drive_en && n < 10000) begin n++; step(); end
    endtask

    task automatic stop_req();
        chan_req = 1'b0;
        step();
        chk(drive_en == 1'b0, "R3 drop", int'(drive_en), 0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        int ok_all;
        chan_req = 1'b1;
        repeat (4) step();
        chk(drive_en == 1'b0, "R1 in reset", int'(drive_en), 0);
        chan_req = 1'b0;
        rst_n = 1'b1;
        repeat (5) step();
        chk(drive_en == 1'b0, "R1 idle", int'(drive_en), 0);

        // R2: direct mode follows the request and ignores current
        cfg_mode = 2'b00; cur_ma = 12'd4000; chan_req = 1'b1;
        step();
        ok_all = 1;
        repeat (60) begin if (!drive_en) ok_all = 0; step(); end
        chk(ok_all == 1, "R2 follow", ok_all, 1);
        stop_req();

        // R4 R5 R6: hold mode over all hold/off code pairs
        for (int h = 0; h < 4; h++) begin
            for (int o = 0; o < 4; o++) begin
                cfg_mode = 2'b01; cfg_hold = 2'(h); cfg_off = 2'(o);
                cur_ma = 12'(e_hold(h)); chan_req = 1'b1;
                step();
                count_high(n);
                chk(n == 20, "R4 blank ext", n, 20);
                cur_ma = 12'(e_hold(h) - 1);
                count_low(n);
                chk(n == 100 * (o + 1), "R6 off time", n, 100 * (o + 1));
                ok_all = 1;
                repeat (60) begin if (!drive_en) ok_all = 0; step(); end
                chk(ok_all == 1, "R5 below hold", ok_all, 1);
                cur_ma = 12'(e_hold(h));
                step();
                chk(drive_en == 1'b0, "R5 at hold", int'(drive_en), 0);
                stop_req();
            end
        end

        // R7: single-peak mode over all peak codes
        for (int p = 0; p < 4; p++) begin
            cfg_mode = 2'b10; cfg_peak = 2'(p); cfg_hold = 2'b01; cfg_off = 2'b00;
            cur_ma = 12'd1000; chan_req = 1'b1;
            step();
            ok_all = 1;
            repeat (30) begin if (!drive_en) ok_all = 0; step(); end
            cur_ma = 12'(e_peak(p) - 1);
            repeat (3) begin if (!drive_en) ok_all = 0; step(); end
            chk(ok_all == 1, "R7 peak phase", ok_all, 1);
            cur_ma = 12'(e_peak(p));
            step();
            chk(drive_en == 1'b0, "R7 at peak", int'(drive_en), 0);
            cur_ma = 12'd1000;
            count_low(n);
            chk(n == 100, "R6 off min-peak", n, 100);
            count_high(n);
            chk(n == 20, "R7 hold after peak", n, 20);
            stop_req();
        end

        // R8: timed peak over all duration codes
        for (int t = 0; t < 8; t++) begin
            cfg_mode = 2'b11; cfg_peak = 2'b11; cfg_hold = 2'b00; cfg_off = 2'b00;
            cfg_tpk = 3'(t); cur_ma = 12'd2000; chan_req = 1'b1;
            step();
            count_high(n);
            chk(n == 800 + 400 * t, "R8 peak time", n, 800 + 400 * t);
            count_low(n);
            chk(n == 100, "R6 off timed", n, 100);
            count_high(n);
            chk(n == 20, "R8 hold level", n, 20);
            stop_req();
        end
        cfg_tpk = 3'b000; cur_ma = 12'd3600; chan_req = 1'b1;
        step();
        count_high(n);
        chk(n == 20, "R8 peak regulated", n, 20);
        stop_req();

        // R3: drop mid off-time restarts cleanly
        cfg_mode = 2'b01; cfg_hold = 2'b00; cfg_off = 2'b11; cur_ma = 12'd700; chan_req = 1'b1;
        step();
        count_high(n);
        repeat (5) step();
        stop_req();
        chan_req = 1'b1;
        step();
        chk(drive_en == 1'b1, "R3 restart on", int'(drive_en), 1);
        count_high(n);
        chk(n == 20, "R3 blank restarted", n, 20);
        stop_req();

        // R9: configuration edits during activation ignored
        cfg_mode = 2'b01; cfg_hold = 2'b11; cur_ma = 12'd1500; chan_req = 1'b1;
        step();
        cfg_hold = 2'b00; cfg_mode = 2'b00;
        ok_all = 1;
        repeat (60) begin if (!drive_en) ok_all = 0; step(); end
        chk(ok_all == 1, "R9 cfg frozen", ok_all, 1);
        stop_req();
        cfg_mode = 2'b01; chan_req = 1'b1;
        step();
        count_high(n);
        chk(n == 20, "R9 new cfg used", n, 20);
        stop_req();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule